// File: doc/BRIEF.md
# Misaligned Transfer Bus Splitter

This block sits between a transfer engine and a 32-bit memory bus. The engine hands it one request at a time: an address, a data size (byte, word or longword), a read/write flag and, for writes, the data. The block turns the request into the smallest number of naturally aligned bus accesses and issues them one after another over a valid/ready handshake. It pulses a completion flag once the final access has been taken.

Values are big-endian. The lowest address holds the most significant byte, and the first access carries the most significant part of the value. For a read, the block collects the bytes that each access returns into one right-justified value. That value is ready when the completion pulse appears.

The split depends only on the size and the two low address bits.
- A word at an odd address becomes two byte accesses.
- A longword at offset 2 becomes two word accesses.
- A longword at an odd offset becomes a byte, then a word, then a byte.

Top module: `xfer_splitter`

## Requirements
- R1: A byte request (size code 0) produces exactly one byte access (bus size code 0) at the request address, for every value of the two low address bits.
- R2: A word request (size code 1) at an even address produces one word access (bus size code 1) at that address. At an odd address it produces two byte accesses, at A and then at A+1.
- R3: A longword request (size code 2) at an address whose two low bits are 0 produces one longword access (bus size code 2) at that address. Size code 3 behaves like code 2.
- R4: A longword request at offset 2 produces two word accesses, at A and then at A+2.
- R5: A longword request at offset 1 or 3 produces three accesses in the order byte at A, word at A+1, byte at A+3.
- R6: Every access is naturally aligned: word accesses sit at even addresses and longword accesses at addresses whose two low bits are 0.
- R7: Lane i is bus data bits [8i+7:8i] and serves address offset i. For each access, lane enable bit i is set exactly for the offsets the access covers, starting at its address's two low bits.
- R8: Write data is big-endian. The byte for address A+k is byte k of the value counted from its most significant end. Each access carries its bytes on its own lanes.
- R9: Read data is assembled big-endian from the lanes of each access. It is zero-extended into the read result, valid when done is high and held until the next request is accepted.
- R10: While an access is offered but not accepted, its address, size, lane enables, write flag and write data stay unchanged.
- R11: The request-ready output is high only while no access is pending. Done is high for exactly one cycle, the cycle right after the final access is accepted. After reset the block is idle with done low and the read result zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request is taken this cycle |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqSize | input | 2 | 0 byte, 1 word, 2 longword |
| reqWrite | input | 1 | 1 write, 0 read |
| reqWdata | input | 32 | Write value, right-justified |
| busValid | output | 1 | Access offered |
| busReady | input | 1 | Bus takes the access this cycle |
| busAddr | output | ADDR_W | Byte address of the access |
| busSize | output | 2 | Access size, same coding as reqSize |
| busWrite | output | 1 | Access direction |
| busLanes | output | 4 | Byte-lane enables |
| busWdata | output | 32 | Write data placed on lanes |
| busRdata | input | 32 | Read data by lane, sampled on acceptance |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Assembled read result |

## Verification
The hardest case to reach is a three-piece longword whose middle word is held off by the bus for several cycles. Hold stability, the advancing address and the partial assembly all interact there. The bench runs every size at all four offsets, both writes and reads, and once with a bus model that accepts only one cycle in four. In that run each piece of a byte-word-byte split sits stalled before it is taken. A small byte-array memory behind the bus lets write placement and read assembly be checked end to end against values computed from the big-endian rule.

// File: rtl/xsplit_pkg.sv
package xsplit_pkg;
  localparam int BUS_BYTES = 4;
  localparam int BUS_W = 8 * BUS_BYTES;
  localparam int LANE_W = $clog2(BUS_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } xsize_e;

  typedef struct packed {
    logic       load;
    logic       step;
    logic [2:0] stepBytes;
  } xstrobe_t;

  function automatic logic [2:0] sizeBytes(xsize_e s);
    case (s)
      SZ_BYTE: sizeBytes = 3'd1;
      SZ_WORD: sizeBytes = 3'd2;
      default: sizeBytes = 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] pieceCount(xsize_e s, logic [1:0] off);
    case (s)
      SZ_BYTE: pieceCount = 2'd1;
      SZ_WORD: pieceCount = off[0] ? 2'd2 : 2'd1;
      default: begin
        if (off == 2'd0)      pieceCount = 2'd1;
        else if (off == 2'd2) pieceCount = 2'd2;
        else                  pieceCount = 2'd3;
      end
    endcase
  endfunction

  function automatic xsize_e pieceSize(xsize_e s, logic [1:0] off, logic [1:0] idx);
    case (s)
      SZ_BYTE: pieceSize = SZ_BYTE;
      SZ_WORD: pieceSize = off[0] ? SZ_BYTE : SZ_WORD;
      default: begin
        if (off == 2'd0)      pieceSize = SZ_LONG;
        else if (off == 2'd2) pieceSize = SZ_WORD;
        else                  pieceSize = (idx == 2'd1) ? SZ_WORD : SZ_BYTE;
      end
    endcase
  endfunction
endpackage

// File: rtl/xsplit_ctrl.sv
module xsplit_ctrl
  import xsplit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqSize,
  input  logic [1:0] reqAddrLow,
  input  logic       busReady,
  output logic       reqReady,
  output logic       busValid,
  output logic [1:0] busSize,
  output xstrobe_t   strobe,
  output logic       done
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_e;

  state_e     stateQ;
  xsize_e     sizeQ;
  logic [1:0] offQ;
  logic [1:0] idxQ;
  logic       doneQ;
  xsize_e     curSize;
  logic [1:0] numPieces;
  logic       lastPiece;

  always_comb begin
    curSize   = pieceSize(sizeQ, offQ, idxQ);
    numPieces = pieceCount(sizeQ, offQ);
    lastPiece = (idxQ == numPieces - 2'd1);
  end

  assign reqReady         = (stateQ == ST_IDLE);
  assign busValid         = (stateQ == ST_BUSY);
  assign busSize          = curSize;
  assign strobe.load      = reqValid && reqReady;
  assign strobe.step      = busValid && busReady;
  assign strobe.stepBytes = sizeBytes(curSize);
  assign done             = doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      sizeQ  <= SZ_BYTE;
      offQ   <= 2'd0;
      idxQ   <= 2'd0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strobe.step && lastPiece;
      if (strobe.load) begin
        stateQ <= ST_BUSY;
        sizeQ  <= xsize_e'(reqSize);
        offQ   <= reqAddrLow;
        idxQ   <= 2'd0;
      end else if (strobe.step) begin
        if (lastPiece) begin
          stateQ <= ST_IDLE;
          idxQ   <= 2'd0;
        end else begin
          idxQ <= idxQ + 2'd1;
        end
      end
    end
  end

  // R11: completion is a single-cycle pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: no new request is taken while an access is pending
  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !reqReady);

  // R2: the piece index never passes the piece count of the split
  assert_piece_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (idxQ < numPieces));
endmodule

// File: rtl/xsplit_path.sv
module xsplit_path
  import xsplit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  xstrobe_t          strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [BUS_W-1:0]  reqWdata,
  input  logic [1:0]        busSize,
  input  logic [BUS_W-1:0]  busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic [BUS_BYTES-1:0] busLanes,
  output logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  rdData
);
  logic [ADDR_W-1:0] addrQ;
  logic [BUS_W-1:0]  wShiftQ;
  logic [BUS_W-1:0]  accQ;
  logic              writeQ;
  logic [2:0]        curBytes;
  logic [2:0]        reqBytes;
  logic [LANE_W-1:0] off;
  logic [BUS_W-1:0]  piece;

  assign curBytes = sizeBytes(xsize_e'(busSize));
  assign reqBytes = sizeBytes(xsize_e'(reqSize));
  assign off      = addrQ[LANE_W-1:0];
  assign busAddr  = addrQ;
  assign busWrite = writeQ;
  assign rdData   = accQ;

  // Lane placement: piece byte k (most significant first) goes to lane off+k.
  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    logic [2:0] rel;
    logic [5:0] shamt;
    assign rel   = 3'(i) - {1'b0, off};
    assign shamt = {3'(BUS_BYTES - 1) - rel, 3'b000};
    assign busLanes[i] = (rel < curBytes);
    assign busWdata[8*i +: 8] = busLanes[i] ? 8'(wShiftQ >> shamt) : 8'h00;
  end

  // Gather the bytes of this piece, first lane as most significant.
  always_comb begin
    piece = '0;
    for (int j = 0; j < BUS_BYTES; j++) begin
      if (3'(j) < curBytes) begin
        piece = (piece << 8) | BUS_W'(8'(busRdata >> {3'(off) + 3'(j), 3'b000}));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wShiftQ <= '0;
      accQ    <= '0;
      writeQ  <= 1'b0;
    end else if (strobe.load) begin
      addrQ   <= reqAddr;
      writeQ  <= reqWrite;
      wShiftQ <= reqWdata << {3'(BUS_BYTES) - reqBytes, 3'b000};
      accQ    <= '0;
    end else if (strobe.step) begin
      addrQ   <= addrQ + ADDR_W'(strobe.stepBytes);
      wShiftQ <= wShiftQ << {strobe.stepBytes, 3'b000};
      if (!writeQ) begin
        accQ <= (accQ << {strobe.stepBytes, 3'b000}) | piece;
      end
    end
  end

  // R6: accepted words and longwords are naturally aligned
  assert_word_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && xsize_e'(busSize) == SZ_WORD) |-> !busAddr[0]);
  assert_long_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && xsize_e'(busSize) == SZ_LONG) |-> (busAddr[1:0] == 2'b00));

  // R7: the number of enabled lanes equals the access size
  assert_lane_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> ($countones(busLanes) == int'(strobe.stepBytes)));
endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
  import xsplit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  output logic              busValid,
  input  logic              busReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              busWrite,
  output logic [3:0]        busLanes,
  output logic [31:0]       busWdata,
  input  logic [31:0]       busRdata,
  output logic              done,
  output logic [31:0]       rdData
);
  xstrobe_t strobe;

  xsplit_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqSize    (reqSize),
    .reqAddrLow (reqAddr[1:0]),
    .busReady   (busReady),
    .reqReady   (reqReady),
    .busValid   (busValid),
    .busSize    (busSize),
    .strobe     (strobe),
    .done       (done)
  );

  xsplit_path #(.ADDR_W(ADDR_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqWrite (reqWrite),
    .reqWdata (reqWdata),
    .busSize  (busSize),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .busLanes (busLanes),
    .busWdata (busWdata),
    .rdData   (rdData)
  );

  // R10: a stalled access is held unchanged
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) && $stable(busSize)
      && $stable(busLanes) && $stable(busWdata) && $stable(busWrite)));

  // R11: done only follows an accepted access
  assert_done_after_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busValid && busReady));
endmodule

// File: tb/sim_xfer_splitter.sv
`timescale 1ns/1ps
module sim_xfer_splitter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        busValid;
  logic        busReady = 1'b0;
  logic [31:0] busAddr;
  logic [1:0]  busSize;
  logic        busWrite;
  logic [3:0]  busLanes;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        done;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] mem [0:255];
  logic       stallMode = 1'b0;
  logic [1:0] stallCnt = '0;
  logic       prevStall = 1'b0;
  logic [31:0] holdAddr, holdWdata;
  logic [1:0]  holdSize;
  logic [3:0]  holdLanes;
  logic        holdWrite;

  int          logCount;
  logic [31:0] logAddr [0:3];
  logic [1:0]  logSize [0:3];
  logic [3:0]  logLanes [0:3];
  logic [31:0] logWdata [0:3];
  logic        logWrite [0:3];
  int          lastAcceptCyc;

  logic [31:0] expAddr [0:3];
  int          expSz [0:3];
  int          expCnt;

  always #5 clk = ~clk;

  xfer_splitter u0 (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .busValid(busValid), .busReady(busReady), .busAddr(busAddr),
    .busSize(busSize), .busWrite(busWrite), .busLanes(busLanes),
    .busWdata(busWdata), .busRdata(busRdata), .done(done), .rdData(rdData)
  );

  always_comb begin
    for (int i = 0; i < 4; i++) busRdata[8*i +: 8] = mem[{busAddr[7:2], 2'(i)}];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Bus model: decides ready at each falling edge, logs what the next rising edge takes.
  always @(negedge clk) begin
    logic rdy;
    cyc++;
    if (prevStall) begin
      check(busValid && busAddr == holdAddr && busSize == holdSize && busLanes == holdLanes
            && busWdata == holdWdata && busWrite == holdWrite,
            "R10", "stalled access changed", busAddr, holdAddr);
    end
    if (busValid) check(!reqReady, "R11", "ready while busy", 32'(reqReady), 32'd0);
    rdy = !stallMode || (stallCnt == 2'd3);
    stallCnt = stallCnt + 2'd1;
    busReady = rdy;
    if (busValid && rdy && logCount < 4) begin
      logAddr[logCount]  = busAddr;
      logSize[logCount]  = busSize;
      logLanes[logCount] = busLanes;
      logWdata[logCount] = busWdata;
      logWrite[logCount] = busWrite;
      logCount++;
      lastAcceptCyc = cyc;
      if (busWrite) begin
        for (int i = 0; i < 4; i++)
          if (busLanes[i]) mem[{busAddr[7:2], 2'(i)}] = busWdata[8*i +: 8];
      end
    end
    prevStall = busValid && !rdy;
    holdAddr = busAddr; holdSize = busSize; holdLanes = busLanes;
    holdWdata = busWdata; holdWrite = busWrite;
  end

  function automatic int nbytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] valByte(input logic [31:0] v, input int n, input int k);
    return 8'(v >> (8 * (n - 1 - k)));
  endfunction

  task automatic planPieces(input int sz, input logic [31:0] a);
    if (sz == 0) begin
      expCnt = 1; expAddr[0] = a; expSz[0] = 0;
    end else if (sz == 1) begin
      if (a[0]) begin
        expCnt = 2; expAddr[0] = a; expSz[0] = 0; expAddr[1] = a + 1; expSz[1] = 0;
      end else begin
        expCnt = 1; expAddr[0] = a; expSz[0] = 1;
      end
    end else begin
      case (a[1:0])
        2'd0: begin expCnt = 1; expAddr[0] = a; expSz[0] = 2; end
        2'd2: begin
          expCnt = 2; expAddr[0] = a; expSz[0] = 1; expAddr[1] = a + 2; expSz[1] = 1;
        end
        default: begin
          expCnt = 3;
          expAddr[0] = a;     expSz[0] = 0;
          expAddr[1] = a + 1; expSz[1] = 1;
          expAddr[2] = a + 3; expSz[2] = 0;
        end
      endcase
    end
  endtask

  task automatic runCase(input int sz, input logic [31:0] a, input bit wr,
                         input logic [31:0] val, input bit stall);
    string splitTag;
    int n;
    int waitCnt;
    int doneCyc;
    logic [31:0] expRead;
    logic [31:0] nval;
    n = nbytes(sz);
    nval = (n == 4) ? val : (val & ((32'd1 << (8 * n)) - 1));
    splitTag = (sz == 0) ? "R1" : (sz == 1) ? "R2" :
               (a[1:0] == 2'd0) ? "R3" : (a[1:0] == 2'd2) ? "R4" : "R5";
    planPieces(sz, a);
    expRead = '0;
    for (int k = 0; k < n; k++) expRead = (expRead << 8) | 32'(mem[8'(a + 32'(k))]);

    @(negedge clk); #1;
    stallMode = stall;
    logCount = 0;
    check(reqReady, "R11", "idle before request", 32'(reqReady), 32'd1);
    reqAddr = a; reqSize = 2'(sz); reqWrite = wr; reqWdata = val; reqValid = 1'b1;
    @(negedge clk); #1;
    reqValid = 1'b0;
    waitCnt = 0;
    while (!done && waitCnt < 60) begin
      @(negedge clk); #1;
      waitCnt++;
    end
    doneCyc = cyc;
    check(done, "R11", "done seen", 32'(done), 32'd1);
    check(doneCyc == lastAcceptCyc + 1, "R11", "done one cycle after last access",
          32'(doneCyc - lastAcceptCyc), 32'd1);
    check(logCount == expCnt, splitTag, "access count", 32'(logCount), 32'(expCnt));
    for (int p = 0; p < expCnt && p < logCount; p++) begin
      int pb;
      logic [3:0] el;
      pb = nbytes(expSz[p]);
      el = 4'(((1 << pb) - 1) << expAddr[p][1:0]);
      check(logAddr[p] == expAddr[p], splitTag, "access address", logAddr[p], expAddr[p]);
      check(logSize[p] == 2'(expSz[p]), splitTag, "access size",
            32'(logSize[p]), 32'(expSz[p]));
      check((expSz[p] != 1 || !logAddr[p][0]) && (expSz[p] != 2 || logAddr[p][1:0] == 0),
            "R6", "alignment", logAddr[p], expAddr[p]);
      check(logLanes[p] == el, "R7", "lane enables", 32'(logLanes[p]), 32'(el));
      check(logWrite[p] == wr, splitTag, "direction", 32'(logWrite[p]), 32'(wr));
      if (wr) begin
        for (int l = 0; l < 4; l++) begin
          if (el[l]) begin
            logic [7:0] eb;
            eb = valByte(nval, n, int'(expAddr[p] - a) + l - int'(expAddr[p][1:0]));
            check(logWdata[p][8*l +: 8] == eb, "R8", "lane write byte",
                  32'(logWdata[p][8*l +: 8]), 32'(eb));
          end
        end
      end
    end
    if (wr) begin
      for (int k = 0; k < n; k++)
        check(mem[8'(a + 32'(k))] == valByte(nval, n, k), "R8", "memory byte",
              32'(mem[8'(a + 32'(k))]), 32'(valByte(nval, n, k)));
    end else begin
      check(rdData == expRead, "R9", "assembled read", rdData, expRead);
    end
    @(negedge clk); #1;
    check(!done, "R11", "done drops", 32'(done), 32'd0);
    if (!wr) check(rdData == expRead, "R9", "read held", rdData, expRead);
    stallMode = 1'b0;
  endtask

  task automatic testReset();
    check(reqReady && !busValid && !done, "R11", "reset idle",
          {29'd0, reqReady, busValid, done}, 32'd4);
    check(rdData == 32'd0, "R11", "reset read result", rdData, 32'd0);
  endtask

  task automatic testByteWrites();
    for (int o = 0; o < 4; o++) runCase(0, 32'h40 + 32'(o), 1'b1, 32'hA0 + 32'(o), 1'b0);
  endtask

  task automatic testWordWrites();
    for (int o = 0; o < 4; o++) runCase(1, 32'h50 + 32'(o), 1'b1, 32'hB1C2 + 32'(o), 1'b0);
  endtask

  task automatic testLongWrites();
    for (int o = 0; o < 4; o++) runCase(2, 32'h60 + 32'(o), 1'b1, 32'h1234_5678 + 32'(o << 8), 1'b0);
  endtask

  task automatic testReads();
    for (int o = 0; o < 4; o++) begin
      runCase(0, 32'h80 + 32'(o), 1'b0, 32'd0, 1'b0);
      runCase(1, 32'h88 + 32'(o), 1'b0, 32'd0, 1'b0);
      runCase(2, 32'h90 + 32'(o), 1'b0, 32'd0, 1'b0);
    end
  endtask

  task automatic testStalled();
    for (int o = 0; o < 4; o++) begin
      runCase(2, 32'hA0 + 32'(o), 1'b1, 32'hDEAD_BEEF ^ 32'(o), 1'b1);
      runCase(2, 32'hA0 + 32'(o), 1'b0, 32'd0, 1'b1);
      runCase(1, 32'hB0 + 32'(o), 1'b0, 32'd0, 1'b1);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    logCount = 0;
    lastAcceptCyc = 0;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    testReset();
    testByteWrites();
    testWordWrites();
    testLongWrites();
    testReads();
    testStalled();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=timeout expected=finished");
    finishRun();
  end
endmodule